// File: doc/BRIEF.md
# Eight-Line Priority Interrupt Controller with End-of-Interrupt Handling

This block collects eight interrupt request lines, ranks them by fixed priority (line 0 highest), and raises a single interrupt toward the processor. Requests are captured on rising edges into a request register. A mask register keeps lines from being delivered. An in-service register records the lines whose handlers are running. An in-service line blocks every line of equal or lower priority. Higher-priority lines can still nest above it.

When the processor pulses acknowledge, the winning request moves from the request register into the in-service register. The controller returns an 8-bit vector: a programmable 5-bit base followed by the 3-bit line number. Software ends service by writing command bytes. One byte clears the highest-priority in-service bit without naming it. A second family of bytes clears one named line. An auto-clear input skips the in-service step entirely.

One line is the attachment point for a secondary controller. Acknowledging it pulses a flag so that the secondary can supply its own vector. The in-service bit of that line here still needs its own end-of-interrupt command.

Top module: `pic_eoi_ctrl`

## Requirements
- R1: After reset the request, in-service and mask registers are all zero, the vector base is zero, and `int_o`, `vec_vld_o` and `casc_ack_o` are low.
- R2: A rising edge on `irq_i[n]` sets request bit n at that clock edge. A line held high does not set the bit again after an acknowledge has cleared it.
- R3: `int_o` is high exactly when the lowest-numbered unmasked request has a smaller index than the lowest-numbered in-service bit, or when the in-service register is empty and an unmasked request exists.
- R4: An acknowledge sampled while `int_o` is high does three things at that edge. It clears the winning line's request bit and sets its in-service bit. It also drives `vec_o = {base, line[2:0]}` with `vec_vld_o` high for one cycle.
- R5: An acknowledge sampled while `int_o` is low returns `{base, 3'd7}` with `vec_vld_o` high and changes neither register.
- R6: Command byte 0x20 clears the lowest-numbered set in-service bit. On an empty in-service register it changes nothing.
- R7: Command byte 0x60+n (n = 0..7, bits 7:3 equal to 01100) clears in-service bit n only.
- R8: While `auto_eoi_i` is high, an acknowledge still clears the request bit and returns the vector, but it leaves the in-service register unchanged.
- R9: A masked line still sets its request bit but does not raise `int_o`. A masked line that is in service is cleared normally by either command.
- R10: Acknowledging line CASC_LINE (default 2) pulses `casc_ack_o` together with `vec_vld_o`. Its in-service bit stays set until a command clears it.
- R11: A second 0x20 command issued after the first clears whichever in-service bit is then lowest-numbered, even if it belongs to a different handler.
- R12: Command bytes other than 0x20 and 0x60..0x67 leave the in-service register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_i | input | 8 | Interrupt request lines, rising-edge captured |
| mask_we_i | input | 1 | Load the mask register |
| mask_i | input | 8 | New mask value, 1 = line blocked |
| base_we_i | input | 1 | Load the vector base |
| base_i | input | 5 | New vector base |
| auto_eoi_i | input | 1 | Acknowledge does not set in-service bits |
| cmd_we_i | input | 1 | Command byte strobe |
| cmd_i | input | 8 | Command byte |
| ack_i | input | 1 | Acknowledge pulse from the processor |
| int_o | output | 1 | Interrupt request to the processor |
| vec_o | output | 8 | Returned vector |
| vec_vld_o | output | 1 | Vector valid, one cycle after acknowledge |
| casc_ack_o | output | 1 | Acknowledged line is the cascade line |
| irr_o | output | 8 | Request register |
| isr_o | output | 8 | In-service register |

## Verification
Directed sequences cover several cases. Nested service on lines 2 and 1 separates correct blocking from a comparison that lets equal or lower lines through. A double non-specific command shows that the second one lands on the cascade line's bit. An acknowledge with nothing pending exposes the spurious vector. A masked in-service line, auto-clear mode and a line held high check the remaining boundaries. Seeded random traffic then mixes edges, acknowledges, all three command kinds, mask changes and mode flips. A reference model checks every register and output on every cycle of that traffic, which catches wrong behaviour when events collide in the same cycle.

// File: rtl/pic_pkg.sv
package pic_pkg;
   localparam logic [7:0] CMD_EOI_ANY     = 8'h20;
   localparam logic [4:0] CMD_EOI_LINE_HI = 5'b01100;
endpackage

// File: rtl/pic_prio_enc.sv
module pic_prio_enc #(
   parameter int N  = 8,
   parameter int IW = $clog2(N)
) (
   input  logic [N-1:0]  vec_i,
   output logic          any_o,
   output logic [IW-1:0] idx_o
);
   always_comb begin
      any_o = 1'b0;
      idx_o = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (vec_i[i]) begin
            any_o = 1'b1;
            idx_o = IW'(i);
         end
      end
   end
endmodule

// File: rtl/pic_req_reg.sv
module pic_req_reg #(
   parameter int N = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] irq_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] irr_o
);
   logic [N-1:0] prev_q;
   logic [N-1:0] rise;

   assign rise = irq_i & ~prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q <= '0;
         irr_o  <= '0;
      end else begin
         prev_q <= irq_i;
         irr_o  <= (irr_o & ~clr_i) | rise;
      end
   end

   assert_edge_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rise != '0) |=> ((irr_o & $past(rise)) == $past(rise)));
endmodule

// File: rtl/pic_svc_reg.sv
module pic_svc_reg
   import pic_pkg::*;
#(
   parameter int N  = 8,
   parameter int IW = $clog2(N)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  set_i,
   input  logic          cmd_we_i,
   input  logic [7:0]    cmd_i,
   output logic [N-1:0]  isr_o,
   output logic          svc_any_o,
   output logic [IW-1:0] svc_idx_o
);
   logic         eoi_any, eoi_line;
   logic [N-1:0] clr;

   pic_prio_enc #(.N(N), .IW(IW)) u_svc_enc (
      .vec_i(isr_o), .any_o(svc_any_o), .idx_o(svc_idx_o));

   assign eoi_any  = cmd_we_i && (cmd_i == CMD_EOI_ANY);
   assign eoi_line = cmd_we_i && (cmd_i[7:3] == CMD_EOI_LINE_HI);

   always_comb begin
      clr = '0;
      if (eoi_any && svc_any_o) clr = N'(1) << svc_idx_o;
      else if (eoi_line)        clr = N'(1) << cmd_i[2:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) isr_o <= '0;
      else        isr_o <= (isr_o & ~clr) | set_i;
   end

   assert_eoi_any_one_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_any && set_i == '0 && isr_o != '0) |=>
         ($countones(isr_o) == $countones($past(isr_o)) - 1));
   assert_eoi_any_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_any && set_i == '0 && isr_o == '0) |=> (isr_o == '0));
   assert_eoi_line_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_line && set_i == '0) |=> !isr_o[$past(cmd_i[2:0])]);
   assert_other_cmd_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_we_i && !eoi_any && !eoi_line && set_i == '0) |=> $stable(isr_o));
endmodule

// File: rtl/pic_eoi_ctrl.sv
module pic_eoi_ctrl #(
   parameter int N_LINES   = 8,
   parameter int BASE_W    = 5,
   parameter int CASC_LINE = 2,
   localparam int IW       = $clog2(N_LINES),
   localparam int VEC_W    = BASE_W + IW
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_LINES-1:0] irq_i,
   input  logic               mask_we_i,
   input  logic [N_LINES-1:0] mask_i,
   input  logic               base_we_i,
   input  logic [BASE_W-1:0]  base_i,
   input  logic               auto_eoi_i,
   input  logic               cmd_we_i,
   input  logic [7:0]         cmd_i,
   input  logic               ack_i,
   output logic               int_o,
   output logic [VEC_W-1:0]   vec_o,
   output logic               vec_vld_o,
   output logic               casc_ack_o,
   output logic [N_LINES-1:0] irr_o,
   output logic [N_LINES-1:0] isr_o
);
   if (N_LINES != 8) begin : g_bad_lines
      $error("pic_eoi_ctrl: command byte encoding needs N_LINES == 8");
   end
   if (CASC_LINE < 0 || CASC_LINE >= N_LINES) begin : g_bad_casc
      $error("pic_eoi_ctrl: CASC_LINE out of range");
   end

   logic [N_LINES-1:0] mask_q;
   logic [BASE_W-1:0]  base_q;
   logic [N_LINES-1:0] pend;
   logic               req_any, svc_any;
   logic [IW-1:0]      req_idx, svc_idx;
   logic               ack_ok;
   logic [N_LINES-1:0] win_1h, irr_clr, isr_set;

   assign pend = irr_o & ~mask_q;

   pic_prio_enc #(.N(N_LINES), .IW(IW)) u_req_enc (
      .vec_i(pend), .any_o(req_any), .idx_o(req_idx));

   assign int_o   = req_any && (!svc_any || req_idx < svc_idx);
   assign ack_ok  = ack_i && int_o;
   assign win_1h  = N_LINES'(1) << req_idx;
   assign irr_clr = ack_ok ? win_1h : '0;
   assign isr_set = (ack_ok && !auto_eoi_i) ? win_1h : '0;

   pic_req_reg #(.N(N_LINES)) u_req (
      .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .clr_i(irr_clr), .irr_o(irr_o));

   pic_svc_reg #(.N(N_LINES), .IW(IW)) u_svc (
      .clk(clk), .rst_n(rst_n), .set_i(isr_set), .cmd_we_i(cmd_we_i),
      .cmd_i(cmd_i), .isr_o(isr_o), .svc_any_o(svc_any), .svc_idx_o(svc_idx));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_q     <= '0;
         base_q     <= '0;
         vec_o      <= '0;
         vec_vld_o  <= 1'b0;
         casc_ack_o <= 1'b0;
      end else begin
         if (mask_we_i) mask_q <= mask_i;
         if (base_we_i) base_q <= base_i;
         vec_vld_o  <= ack_i;
         casc_ack_o <= ack_ok && (req_idx == IW'(CASC_LINE));
         if (ack_i) vec_o <= {base_q, ack_ok ? req_idx : IW'(N_LINES - 1)};
      end
   end

   assert_int_needs_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
      int_o |-> ((irr_o & ~mask_q) != '0));
   assert_vld_after_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
      vec_vld_o |-> $past(ack_i));
   assert_ack_takes_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_ok && !cmd_we_i && !auto_eoi_i) |=> ($countones(isr_o) == $countones($past(isr_o)) + 1));
   assert_spurious_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && !int_o && !cmd_we_i) |=> $stable(isr_o));
   assert_auto_eoi_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && auto_eoi_i && !cmd_we_i) |=> $stable(isr_o));
   assert_masked_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ((irr_o & ~mask_q) == '0) |-> !int_o);
   assert_casc_with_vec_R10: assert property (@(posedge clk) disable iff (!rst_n)
      casc_ack_o |-> vec_vld_o);
endmodule

// File: tb/pic_eoi_ctrl_bench.sv
module pic_eoi_ctrl_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] d_irq = '0, d_mask = '0, d_cmd = '0;
   logic [4:0] d_base = '0;
   logic       d_mask_we = 0, d_base_we = 0, d_auto = 0, d_cmd_we = 0, d_ack = 0;
   logic       int_o, vec_vld_o, casc_ack_o;
   logic [7:0] vec_o, irr_o, isr_o;

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   logic [7:0] m_irr, m_isr, m_mask, m_prev, m_vec;
   logic [4:0] m_base;
   logic       m_vld, m_casc;

   always #5 clk = ~clk;

   pic_eoi_ctrl u_pic_eoi_ctrl (
      .clk(clk), .rst_n(rst_n), .irq_i(d_irq), .mask_we_i(d_mask_we), .mask_i(d_mask),
      .base_we_i(d_base_we), .base_i(d_base), .auto_eoi_i(d_auto), .cmd_we_i(d_cmd_we),
      .cmd_i(d_cmd), .ack_i(d_ack), .int_o(int_o), .vec_o(vec_o), .vec_vld_o(vec_vld_o),
      .casc_ack_o(casc_ack_o), .irr_o(irr_o), .isr_o(isr_o));

   function automatic int lowest(input logic [7:0] v);
      for (int i = 0; i < 8; i++) if (v[i]) return i;
      return 8;
   endfunction

   function automatic logic exp_int();
      int r = lowest(m_irr & ~m_mask);
      return (r < 8) && (r < lowest(m_isr));
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic model_edge();
      logic [7:0] rise, iclr, iset, eclr;
      int r, s;
      rise = d_irq & ~m_prev;
      r = lowest(m_irr & ~m_mask);
      s = lowest(m_isr);
      iclr = '0; iset = '0; eclr = '0;
      m_vld = d_ack; m_casc = 1'b0;
      if (d_ack) begin
         if (exp_int()) begin
            iclr = 8'(1) << r;
            if (!d_auto) iset = 8'(1) << r;
            m_vec = {m_base, 3'(r)};
            m_casc = (r == 2);
         end else m_vec = {m_base, 3'd7};
      end
      if (d_cmd_we && d_cmd == 8'h20 && s < 8) eclr = 8'(1) << s;
      if (d_cmd_we && d_cmd[7:3] == 5'b01100) eclr = 8'(1) << d_cmd[2:0];
      m_irr = (m_irr & ~iclr) | rise;
      m_isr = (m_isr & ~eclr) | iset;
      m_prev = d_irq;
      if (d_mask_we) m_mask = d_mask;
      if (d_base_we) m_base = d_base;
   endtask

   task automatic tick();
      @(posedge clk);
      model_edge();
      @(negedge clk);
      chk("R2 irr", irr_o, m_irr);
      chk("R6 isr", isr_o, m_isr);
      chk("R3 int", int_o, exp_int());
      chk("R4 vld", vec_vld_o, m_vld);
      if (m_vld) chk("R4 vec", vec_o, m_vec);
      chk("R10 casc", casc_ack_o, m_casc);
      d_ack = 0; d_cmd_we = 0; d_mask_we = 0; d_base_we = 0;
   endtask

   task automatic pulse(input int n);
      d_irq[n] = 1'b1; tick();
      d_irq[n] = 1'b0; tick();
   endtask
   task automatic ack();                    d_ack = 1; tick(); endtask
   task automatic cmd(input logic [7:0] b); d_cmd_we = 1; d_cmd = b; tick(); endtask
   task automatic set_mask(input logic [7:0] m); d_mask_we = 1; d_mask = m; tick(); endtask

   initial begin
      #2_000_000;
      if (!done) begin
         n_fail++; n_chk++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_0c1a));
      m_irr = 0; m_isr = 0; m_mask = 0; m_prev = 0; m_base = 0; m_vec = 0; m_vld = 0; m_casc = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state (no edge since release changes anything)
      chk("R1 irr", irr_o, 8'h00); chk("R1 isr", isr_o, 8'h00);
      chk("R1 int", int_o, 1'b0);  chk("R1 vld", vec_vld_o, 1'b0);
      chk("R1 casc", casc_ack_o, 1'b0);
      @(posedge clk); model_edge(); @(negedge clk);

      d_base_we = 1; d_base = 5'h09; tick();
      // R10 cascade line nests under line 1
      pulse(2);
      chk("R2 edge sets bit", irr_o, 8'h04);
      chk("R3 int raised", int_o, 1'b1);
      ack();
      chk("R10 casc pulse", casc_ack_o, 1'b1);
      chk("R4 vector", vec_o, {5'h09, 3'd2});
      chk("R4 in service", isr_o, 8'h04);
      pulse(1); pulse(5);
      chk("R3 higher nests", int_o, 1'b1);
      ack();
      chk("R4 nested vec", vec_o, {5'h09, 3'd1});
      chk("R4 nested isr", isr_o, 8'h06);
      chk("R3 lower blocked", int_o, 1'b0);
      cmd(8'h20);
      chk("R6 clears lowest", isr_o, 8'h04);
      chk("R10 cascade still held", int_o, 1'b0);
      cmd(8'h20);
      chk("R11 second clears cascade", isr_o, 8'h00);
      chk("R3 line5 released", int_o, 1'b1);
      ack();
      chk("R4 line5 isr", isr_o, 8'h20);
      cmd(8'h13);
      chk("R12 other byte ignored", isr_o, 8'h20);
      cmd(8'h65);
      chk("R7 named clear", isr_o, 8'h00);
      cmd(8'h20);
      chk("R6 empty no change", isr_o, 8'h00);
      // R5 spurious
      ack();
      chk("R5 spurious vld", vec_vld_o, 1'b1);
      chk("R5 spurious vec", vec_o, {5'h09, 3'd7});
      chk("R5 isr kept", isr_o, 8'h00);
      // R9 masking
      set_mask(8'h08);
      pulse(3);
      chk("R9 masked captured", irr_o, 8'h08);
      chk("R9 masked quiet", int_o, 1'b0);
      set_mask(8'h00);
      chk("R9 unmasked raises", int_o, 1'b1);
      ack();
      set_mask(8'h08);
      chk("R9 masked in service", isr_o, 8'h08);
      cmd(8'h63);
      chk("R9 masked line cleared", isr_o, 8'h00);
      set_mask(8'h00);
      // R8 auto clear
      d_auto = 1;
      pulse(4);
      ack();
      chk("R8 vec", vec_o, {5'h09, 3'd4});
      chk("R8 isr untouched", isr_o, 8'h00);
      chk("R8 irr cleared", irr_o, 8'h00);
      d_auto = 0;
      // R2 held level does not re-request
      d_irq[6] = 1'b1; tick(); tick();
      ack(); tick(); tick();
      chk("R2 held no re-set", irr_o, 8'h00);
      d_irq[6] = 1'b0; tick();
      cmd(8'h66);
      chk("R7 cleanup", isr_o, 8'h00);

      // seeded random traffic checked every cycle
      for (int k = 0; k < 5000; k++) begin
         for (int b = 0; b < 8; b++) if ($urandom_range(7) == 0) d_irq[b] = ~d_irq[b];
         d_ack = ($urandom_range(3) == 0);
         if ($urandom_range(4) == 0) begin
            d_cmd_we = 1;
            case ($urandom_range(2))
               0: d_cmd = 8'h20;
               1: d_cmd = 8'h60 + 8'($urandom_range(7));
               default: d_cmd = 8'($urandom);
            endcase
         end
         if ($urandom_range(39) == 0) begin d_mask_we = 1; d_mask = 8'($urandom & $urandom); end
         if ($urandom_range(49) == 0) begin d_base_we = 1; d_base = 5'($urandom); end
         if ($urandom_range(199) == 0) d_auto = ~d_auto;
         tick();
      end

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule